// File: doc/BRIEF.md
# Three-Slot Shared-Port Register File

This block is an 8-bit slice of a processor register file holding 32 words. The storage array has a single access port, yet each processor cycle it serves two operand reads and one result write, so the datapath sees a file with two read ports and one write port. Four slices placed side by side give a 32-bit datapath.

A fast clock runs at three times the processor rate and steps a slot counter through three fixed slots: the first reads operand A, the second reads operand B, the third writes. A one-cycle cycle-start strobe forces the counter back to the first slot. Each read result passes through a per-port multiplexer into an operand register that holds its value until that port's next slot. The multiplexer can load an external data value in place of the array word, so an operand can come from off-chip without touching the array. All inputs for a processor cycle are held steady across its three fast-clock edges.

Top module: `slotted_regfile`

## Requirements
- R1: After reset both operand outputs are zero, and every storage word reads back as zero.
- R2: The fast-clock edge sampled with the cycle-start strobe high is the operand-A read slot. Without the strobe, the next edge is the operand-B read slot, the edge after that is the write slot, and the slots then repeat in that order.
- R3: `op_a` changes only at the end of an operand-A slot. At that edge it takes the word at `rd_addr_a`, or `ext_data` when `byp_sel_a` is 1.
- R4: `op_b` changes only at the end of an operand-B slot. At that edge it takes the word at `rd_addr_b`, or `ext_data` when `byp_sel_b` is 1.
- R5: At the end of a write slot with `wr_en` = 1, `wr_data` is stored at `wr_addr` and is returned by any later read of that address.
- R6: A write slot with `wr_en` = 0 leaves every word unchanged.
- R7: When a bypass select is 1, that operand output takes `ext_data` and the array word at its read address is ignored.
- R8: A read and a write to the same address in one processor cycle return the old word. The new word is returned from the next cycle on.
- R9: The slot counter never leaves its three states. It wraps from the write slot to the A slot without a strobe, and a strobe in the middle of a cycle restarts it at the A slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, three edges per processor cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_start | input | 1 | Processor-cycle start strobe; forces the operand-A slot |
| rd_addr_a | input | 5 | Read address for operand A |
| rd_addr_b | input | 5 | Read address for operand B |
| wr_addr | input | 5 | Write address |
| wr_data | input | 8 | Write data |
| wr_en | input | 1 | Write enable for the write slot |
| ext_data | input | 8 | External data for either operand |
| byp_sel_a | input | 1 | Load operand A from ext_data |
| byp_sel_b | input | 1 | Load operand B from ext_data |
| op_a | output | 8 | Operand A register |
| op_b | output | 8 | Operand B register |

## Verification
The bench builds the block with its default 32 words of 8 bits, so the random sequences can reach every address and every data pattern. Part of the random traffic restricts addresses to four words. This makes same-cycle read/write collisions and back-to-back overwrites frequent, and these stress the read-before-write slot order. Directed steps cover the free-running wrap and a strobe placed in the middle of a cycle.

// File: rtl/slotted_regfile.sv
module slotted_regfile #(
  parameter int WORDS = 32,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_start,
  input  logic [AW-1:0]    rd_addr_a,
  input  logic [AW-1:0]    rd_addr_b,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] ext_data,
  input  logic             byp_sel_a,
  input  logic             byp_sel_b,
  output logic [WIDTH-1:0] op_a,
  output logic [WIDTH-1:0] op_b
);
  localparam logic [1:0] SLOT_A = 2'd0;
  localparam logic [1:0] SLOT_B = 2'd1;
  localparam logic [1:0] SLOT_W = 2'd2;

  logic [WIDTH-1:0] mem [WORDS];
  logic [1:0]       slot_q;
  logic [1:0]       slot;
  logic [AW-1:0]    port_addr;
  logic             port_we;
  logic [WIDTH-1:0] port_rd;

  assign slot      = cyc_start ? SLOT_A : slot_q;
  assign port_addr = (slot == SLOT_A) ? rd_addr_a :
                     (slot == SLOT_B) ? rd_addr_b : wr_addr;
  assign port_we   = (slot == SLOT_W) && wr_en;
  assign port_rd   = mem[port_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q <= SLOT_A;
      op_a   <= '0;
      op_b   <= '0;
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else begin
      slot_q <= (slot == SLOT_W) ? SLOT_A : 2'(slot + 2'd1);
      if (port_we) mem[port_addr] <= wr_data;
      if (slot == SLOT_A) op_a <= byp_sel_a ? ext_data : port_rd;
      if (slot == SLOT_B) op_b <= byp_sel_b ? ext_data : port_rd;
    end
  end
endmodule

// File: rtl/slotted_regfile_chk.sv
module slotted_regfile_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cyc_start,
  input logic [1:0]       slot_q,
  input logic             byp_sel_a,
  input logic             byp_sel_b,
  input logic [WIDTH-1:0] ext_data,
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b
);
  assert_slot_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q != 2'd3);

  assert_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_start && slot_q == 2'd2) |=> slot_q == 2'd0);

  assert_strobe_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |=> slot_q == 2'd1);

  assert_hold_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_start && slot_q != 2'd0) |=> $stable(op_a));

  assert_hold_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start || slot_q != 2'd1) |=> $stable(op_b));

  assert_bypass_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((cyc_start || slot_q == 2'd0) && byp_sel_a) |=> op_a == $past(ext_data));

  assert_bypass_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_start && slot_q == 2'd1 && byp_sel_b) |=> op_b == $past(ext_data));
endmodule

bind slotted_regfile slotted_regfile_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .slot_q(slot_q),
  .byp_sel_a(byp_sel_a), .byp_sel_b(byp_sel_b), .ext_data(ext_data),
  .op_a(op_a), .op_b(op_b)
);

// File: tb/slotted_regfile_tb.sv
module slotted_regfile_tb;
  localparam int WORDS = 32;
  localparam int WIDTH = 8;
  localparam int AW = $clog2(WORDS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_start = 1'b0;
  logic [AW-1:0] rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
  logic [WIDTH-1:0] wr_data = '0, ext_data = '0;
  logic wr_en = 1'b0, byp_sel_a = 1'b0, byp_sel_b = 1'b0;
  logic [WIDTH-1:0] op_a, op_b;

  logic [WIDTH-1:0] ref_mem [WORDS];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  slotted_regfile #(.WORDS(WORDS), .WIDTH(WIDTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start),
    .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_en(wr_en), .ext_data(ext_data),
    .byp_sel_a(byp_sel_a), .byp_sel_b(byp_sel_b), .op_a(op_a), .op_b(op_b)
  );

  task automatic check(input string req, input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [WIDTH-1:0] pick(input logic sel, input logic [WIDTH-1:0] ext,
                                            input logic [WIDTH-1:0] word);
    return sel ? ext : word;
  endfunction

  // one processor cycle; inputs held for three edges; checks after each edge
  task automatic proc_cycle(input logic [AW-1:0] ra, input logic [AW-1:0] rb,
                            input logic [AW-1:0] wa, input logic [WIDTH-1:0] wd,
                            input logic we, input logic ba, input logic bb,
                            input logic [WIDTH-1:0] ext, input string req);
    logic [WIDTH-1:0] exp_a, exp_b, old_b;
    exp_a = pick(ba, ext, ref_mem[ra]);
    exp_b = pick(bb, ext, ref_mem[rb]);
    old_b = op_b;
    rd_addr_a = ra; rd_addr_b = rb; wr_addr = wa; wr_data = wd;
    wr_en = we; byp_sel_a = ba; byp_sel_b = bb; ext_data = ext;
    cyc_start = 1'b1;
    @(negedge clk);
    cyc_start = 1'b0;
    check({req, " R3 A slot"}, op_a, exp_a);
    check({req, " R4 B held"}, op_b, old_b);
    @(negedge clk);
    check({req, " R4 B slot"}, op_b, exp_b);
    check({req, " R3 A held"}, op_a, exp_a);
    @(negedge clk);
    check({req, " R8 reads precede write"}, op_a, exp_a);
    if (we) ref_mem[wa] = wd;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < WORDS; i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 op_a reset", op_a, '0);
    check("R1 op_b reset", op_b, '0);

    for (int i = 0; i < WORDS; i += 2)
      proc_cycle(AW'(i), AW'(i + 1), '0, 8'hFF, 1'b0, 1'b0, 1'b0, 8'h00, "R1 R6 zero array");

    for (int i = 0; i < WORDS; i++)
      proc_cycle(AW'(i), AW'((i + 5) % WORDS), AW'(i), WIDTH'(8'h3C ^ i * 7), 1'b1,
                 1'b0, 1'b0, 8'h00, "R5 fill");

    // R8: same address read and written in one cycle
    proc_cycle(5'd9, 5'd9, 5'd9, 8'hA5, 1'b1, 1'b0, 1'b0, 8'h00, "R8 collide");
    proc_cycle(5'd9, 5'd9, 5'd0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, "R8 next cycle");
    check("R8 new word visible", op_a, 8'hA5);

    // R6: write slot with enable low
    proc_cycle(5'd3, 5'd4, 5'd3, 8'h77, 1'b0, 1'b0, 1'b0, 8'h00, "R6 idle write");
    proc_cycle(5'd3, 5'd4, 5'd0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, "R6 readback");
    check("R6 word unchanged", op_a, ref_mem[3]);

    // R7: bypass both ports
    proc_cycle(5'd1, 5'd2, 5'd0, 8'h00, 1'b0, 1'b1, 1'b1, 8'h5E, "R7 bypass");
    check("R7 op_a from ext", op_a, 8'h5E);
    check("R7 op_b from ext", op_b, 8'h5E);

    // R9/R2: free-running wrap without strobe starts a new A slot
    rd_addr_a = 5'd12; byp_sel_a = 1'b0; byp_sel_b = 1'b0;
    @(negedge clk);
    check("R9 wrap to A slot", op_a, ref_mem[12]);
    check("R2 B held at A slot", op_b, 8'h5E);
    rd_addr_b = 5'd13;
    @(negedge clk);
    check("R2 B slot follows A", op_b, ref_mem[13]);
    // R9: strobe while counter sits at write slot
    rd_addr_a = 5'd14; rd_addr_b = 5'd15; wr_en = 1'b0; cyc_start = 1'b1;
    @(negedge clk);
    cyc_start = 1'b0;
    check("R9 mid strobe A", op_a, ref_mem[14]);
    check("R9 mid strobe B held", op_b, ref_mem[13]);
    @(negedge clk);
    check("R9 B after strobe", op_b, ref_mem[15]);
    @(negedge clk);

    // random traffic, some confined to four addresses
    for (int n = 0; n < 400; n++) begin
      logic [AW-1:0] m;
      m = (n % 2 == 0) ? AW'(3) : AW'(WORDS - 1);
      proc_cycle(AW'($urandom) & m, AW'($urandom) & m, AW'($urandom) & m,
                 WIDTH'($urandom), 1'($urandom % 3 != 0),
                 1'($urandom % 5 == 0), 1'($urandom % 5 == 0),
                 WIDTH'($urandom), "R5 R7 R8 random");
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule